// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog counter that advances on a slow tick strobe coming from a separate low-frequency source. The tick is a single-cycle enable in the system clock domain. When the count reaches the selected period, the block does one of three things: it fires a one-cycle reset pulse, it sets an interrupt flag (useful as a wake-up source), or, when both are enabled, it raises the interrupt first and resets on the following timeout unless software re-arms the interrupt enable. Software restarts the count with a kick strobe.

The enable bit and the 4-bit period code are guarded. A write that sets both the unlock bit and the enable bit opens a short change window, and only a write made inside that window may alter them. A fuse-level safety input forces the watchdog on and makes the enable read as one. Even at that level, the period can still be changed only through the window.

Top module: `wdt_guard`

Control byte layout, used for both writes and reads: bit 7 is the interrupt flag (writing 1 clears it), bit 6 is the interrupt enable, bit 5 is period code bit 3, bit 4 is the unlock bit (reads 1 while the window is open), bit 3 is the enable, and bits 2:0 are period code bits 2:0.

## Requirements
- R1: After reset, with the safety input low, the control read-back is 0x00, and both the reset pulse and the interrupt request are low.
- R2: With the enable set and the interrupt enable clear, the reset pulse rises after exactly 2^(BASE_LOG2+code) ticks counted from the last clear of the counter, and it stays high for exactly one clock cycle.
- R3: With only the interrupt enable set, a timeout sets the flag (bit 7) and no reset pulse occurs. The interrupt request equals the flag ANDed with the interrupt enable.
- R4: With both enables set, a timeout sets the flag. An interrupt acknowledge clears both the flag and the interrupt enable. The next timeout then gives a reset pulse, unless the interrupt enable has been written back to 1, in which case it sets the flag again.
- R5: A write with bits 4 and 3 both set, made while the window is closed, opens the window, which reads as bit 4 = 1. A write made while the window is open loads the enable and the period code from the data and closes the window.
- R6: The window accepts a write only on the first through fourth clock edges after the opening write. A write on the fifth edge changes neither the enable nor the period code.
- R7: A write made while the window is closed leaves the enable and the period code unchanged.
- R8: While the safety input is high, the enable reads as 1 and the watchdog keeps running, even after 0 is written to the enable inside the window. Changing the period code still requires the window.
- R9: Period codes above MAX_CODE give the same period as MAX_CODE.
- R10: A kick clears the counter to zero, takes priority over a tick in the same cycle, and leaves the control read-back unchanged.
- R11: Writing 1 to bit 7 clears the flag. The interrupt enable follows bit 6 on every write, whether or not the window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| safety_on | input | 1 | Fuse level that forces the watchdog on |
| tick | input | 1 | Low-frequency count strobe |
| kick | input | 1 | Counter restart strobe |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control write data |
| irq_ack | input | 1 | Interrupt taken |
| rst_pulse | output | 1 | One-cycle watchdog reset |
| irq_req | output | 1 | Interrupt request |
| ctrl_rd | output | 8 | Control read-back |

## Verification
The bench builds the block with BASE_LOG2 = 2, while MAX_CODE and the window length keep their defaults. Periods then run from 4 to 2048 ticks, so all sixteen period codes can be swept to their exact timeout cycle, including the six reserved codes that must saturate. The short periods also let the interrupt-then-reset sequence, the safety level and every window offset be exercised back to back.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_CODE  = 9,
  parameter int WIN_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       safety_on,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       irq_ack,
  output logic       rst_pulse,
  output logic       irq_req,
  output logic [7:0] ctrl_rd
);
  localparam int CNT_W = BASE_LOG2 + MAX_CODE + 1;
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic             en_q, ie_q, flag_q, rst_q;
  logic [3:0]       code_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [3:0]       code_sat;

  wire win_open = win_q != '0;
  wire en_eff   = en_q | safety_on;
  wire active   = en_eff | ie_q;
  wire hit      = active & tick & ~kick & (cnt_q >= lim);

  assign code_sat = (code_q > 4'(MAX_CODE)) ? 4'(MAX_CODE) : code_q;
  assign lim      = (CNT_W'(1) << (BASE_LOG2 + int'(code_sat))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (kick || !active) cnt_q <= '0;
    else if (tick)            cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= hit & ~ie_q & en_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            flag_q <= 1'b0;
    else if (hit && ie_q)                  flag_q <= 1'b1;
    else if (irq_ack || (wr_en && wr_data[7])) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ie_q <= 1'b0;
    else begin
      if (wr_en)             ie_q <= wr_data[6];
      if (irq_ack && en_eff) ie_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (wr_en && win_open) begin
      en_q   <= wr_data[3];
      code_q <= {wr_data[5], wr_data[2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               win_q <= '0;
    else if (wr_en && win_open)               win_q <= '0;
    else if (wr_en && wr_data[4] && wr_data[3]) win_q <= WIN_W'(WIN_CYC);
    else if (win_open)                        win_q <= win_q - WIN_W'(1);
  end

  assign rst_pulse = rst_q;
  assign irq_req   = flag_q & ie_q;
  assign ctrl_rd   = {flag_q, ie_q, code_q[3], win_open, en_eff, code_q[2:0]};
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       safety_on,
  input logic       kick,
  input logic       wr_en,
  input logic       irq_ack,
  input logic       rst_pulse,
  input logic       irq_req,
  input logic [7:0] ctrl_rd
);
  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  // R3
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ctrl_rd[7]);
  // R7
  locked_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[4] |=> $stable({ctrl_rd[5], ctrl_rd[2:0]}));
  // R8
  safety_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    safety_on |-> ctrl_rd[3]);
  // R10
  kick_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rst_pulse);
  // R4
  ack_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && ctrl_rd[3] && !wr_en |=> !ctrl_rd[6] && !ctrl_rd[7]);
  // R5
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[4]) |-> $past(wr_en));
endmodule

bind wdt_guard wdt_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .safety_on(safety_on), .kick(kick),
  .wr_en(wr_en), .irq_ack(irq_ack), .rst_pulse(rst_pulse),
  .irq_req(irq_req), .ctrl_rd(ctrl_rd)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb_top;
  localparam int B = 2;
  localparam int MC = 9;

  logic clk = 1'b0, rst_n = 1'b0, safety_on = 1'b0, tick = 1'b0, kick = 1'b0;
  logic wr_en = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_pulse, irq_req;
  logic [7:0] ctrl_rd;
  int errors = 0, checks = 0, cyc = 0;

  wdt_guard #(.BASE_LOG2(B), .MAX_CODE(MC), .WIN_CYC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .safety_on(safety_on), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .irq_ack(irq_ack),
    .rst_pulse(rst_pulse), .irq_req(irq_req), .ctrl_rd(ctrl_rd));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit saf);
    rst_n = 1'b0; safety_on = saf; tick = 1'b0; kick = 1'b0; wr_en = 1'b0; irq_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input bit do_kick, output int n, output bit r, output bit f);
    n = 0; r = 0; f = 0;
    kick = do_kick; tick = 1'b1;
    while (n < 5000) begin
      @(negedge clk);
      kick = 1'b0;
      n++;
      r = rst_pulse; f = ctrl_rd[7];
      if (r || f) break;
    end
    tick = 1'b0;
  endtask

  initial begin
    int n; bit r, f; int per; logic [7:0] v;
    @(negedge clk);
    do_reset(1'b0);
    // R1
    chk(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
    chk(!rst_pulse && !irq_req, "R1 outputs", {rst_pulse, irq_req}, 0);

    // R5 / R6: window accepts the fourth edge after opening
    wr(8'h18);
    chk(ctrl_rd[4], "R5 window visible", ctrl_rd, 8'h10);
    repeat (3) @(negedge clk);
    wr(8'h0A);
    chk(ctrl_rd == 8'h0A, "R6 edge4 accepted", ctrl_rd, 8'h0A);
    wr(8'h18);
    repeat (4) @(negedge clk);
    chk(!ctrl_rd[4], "R6 window closed", ctrl_rd, 8'h0A);
    wr(8'h03);
    chk(ctrl_rd == 8'h0A, "R6 edge5 ignored", ctrl_rd, 8'h0A);
    // R7
    wr(8'h05);
    chk(ctrl_rd == 8'h0A, "R7 locked write", ctrl_rd, 8'h0A);

    // R2 / R9: sweep every period code in reset mode
    for (int c = 0; c < 16; c++) begin
      v = {2'b00, c[3], 2'b01, c[2:0]};
      wr(8'h18); wr(v);
      chk(ctrl_rd == v, "R5 code load", ctrl_rd, v);
      per = 1 << (B + ((c > MC) ? MC : c));
      measure(1'b1, n, r, f);
      chk(r && n == per + 1, (c > MC) ? "R9 reserved period" : "R2 period", n, per + 1);
      @(negedge clk);
      chk(!rst_pulse, "R2 one cycle", rst_pulse, 0);
    end

    // R10: kick restarts a partly advanced count
    wr(8'h18); wr(8'h09);
    tick = 1'b1; repeat (6) @(negedge clk); tick = 1'b0;
    measure(1'b1, n, r, f);
    chk(r && n == 9, "R10 kick clears", n, 9);
    chk(ctrl_rd == 8'h09, "R10 config kept", ctrl_rd, 8'h09);

    // R3 / R11: interrupt-only mode
    do_reset(1'b0);
    wr(8'h40);
    measure(1'b1, n, r, f);
    chk(f && !r && n == 5, "R3 flag timing", n, 5);
    chk(irq_req, "R3 irq_req", irq_req, 1);
    wr(8'hC0);
    chk(ctrl_rd == 8'h40 && !irq_req, "R11 flag clear", ctrl_rd, 8'h40);

    // R4: interrupt then reset
    wr(8'h18); wr(8'h48);
    measure(1'b1, n, r, f);
    chk(f && !r && n == 5, "R4 first flag", n, 5);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk(ctrl_rd == 8'h08, "R4 ack disarms", ctrl_rd, 8'h08);
    measure(1'b0, n, r, f);
    chk(r && !f && n == 4, "R4 second timeout resets", n, 4);
    wr(8'h40);
    measure(1'b1, n, r, f);
    chk(f && !r && n == 5, "R4 rearmed flags", n, 5);

    // R8: safety level
    do_reset(1'b1);
    chk(ctrl_rd == 8'h08, "R8 enable forced", ctrl_rd, 8'h08);
    measure(1'b1, n, r, f);
    chk(r && n == 5, "R8 runs", n, 5);
    wr(8'h18); wr(8'h01);
    chk(ctrl_rd == 8'h09, "R8 disable refused", ctrl_rd, 8'h09);
    measure(1'b1, n, r, f);
    chk(r && n == 9, "R8 new period", n, 9);
    wr(8'h05);
    chk(ctrl_rd == 8'h09, "R8 code locked", ctrl_rd, 8'h09);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule